// File: doc/BRIEF.md
# CAN Bus Remote Wake-Up Detector

This block sits beside the low-power bus receiver of a CAN node. While the node is in standby it watches a sampled, already-digitised "bus is dominant" bit. From that bit it decides whether a remote node has requested a wake-up. All durations are counted in clock cycles and set by parameters. The first is the minimum length a bus phase must hold to count, called the filter time. The second is the overall window in which a pattern must complete.

Two methods can be selected. In basic mode a single dominant phase that holds for the filter time is enough. In pattern mode the bus must show three phases in turn: dominant, then recessive, then dominant, each held for the filter time. The window opens when the first dominant phase is accepted. If the window runs out first, or any phase ends early, the sequence starts again from the beginning.

A valid wake-up produces a one-cycle event pulse. From then on the standby receive-data output follows the bus, so the controller sees a falling edge as its interrupt. Until that moment the output is held recessive (high). The detector only runs while its enable is high, meaning the node is in standby with both supplies valid. After a wake-up it stays quiet until the enable is dropped and raised again.

Top module: `can_wake_detect`

## Requirements
- R1: In basic mode (`pattern_mode`=0), a dominant phase lasting at least FILT_CYC cycles produces exactly one `wake_pulse`.
- R2: In basic mode, dominant phases shorter than FILT_CYC cycles produce no `wake_pulse`, even when several of them are separated by short recessive gaps.
- R3: In pattern mode (`pattern_mode`=1), a sequence of dominant, recessive and dominant phases, each lasting at least FILT_CYC cycles and completed inside the window, produces exactly one `wake_pulse`.
- R4: In pattern mode, a phase shorter than FILT_CYC cycles sends the sequence back to waiting for a first dominant phase. A later dominant phase only counts as a new first phase, so no wake-up follows from it.
- R5: In pattern mode, the window of WIN_CYC cycles opens when the first dominant phase is accepted. If it expires before the second dominant phase qualifies, no wake-up occurs and a full new pattern is needed.
- R6: `rxd_lp` stays high (recessive) after reset, while `wake_en` is low, and at all times before a wake-up has been detected.
- R7: After a wake-up, `rxd_lp` follows the bus: low while `bus_dom`=1 and high while `bus_dom`=0, a few cycles behind the input.
- R8: `wake_pulse` lasts one cycle. After it, further bus activity causes no new pulse until `wake_en` is dropped and raised again.
- R9: While `wake_en` is low, no `wake_pulse` is produced, whatever the bus does.
- R10: After a synchronous reset, `wake_pulse` is 0 and `rxd_lp` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_en | input | 1 | Detection enabled (standby, supplies valid); low re-arms the detector |
| bus_dom | input | 1 | Sampled low-power receiver output, 1 = dominant |
| pattern_mode | input | 1 | 0 = basic wake-up, 1 = three-phase pattern wake-up |
| wake_pulse | output | 1 | One-cycle wake-up event |
| rxd_lp | output | 1 | Standby receive data, 1 = recessive |

## Verification
The stimulus places every phase one cycle below and one cycle above the filter time. A filter that counts off by one would then either wake on a glitch or miss a legal pattern. Some patterns finish well inside the window, and others have a long recessive gap or a long first dominant phase that pushes completion past it. A timer started at the wrong point, or never cleared, shows up as a false or missing pulse. A glitch in the middle of the pattern followed by a good dominant phase catches a design that resumes the old sequence instead of restarting it. Directed cases also check that the output stays silent and recessive after a wake-up, and that it re-arms only through the enable.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a first qualified dominant phase
    S_DOM1,   // first dominant accepted, still dominant
    S_WREC,   // recessive phase under way, not yet long enough
    S_REC,    // recessive phase accepted
    S_WDOM2,  // second dominant under way, not yet long enough
    S_AWAKE   // wake-up reported, bus ignored until re-armed
  } wk_state_e;
endpackage

// File: rtl/wk_phase_filter.sv
module wk_phase_filter #(
  parameter int FILT_CYC = 450
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bus_dom,
  output logic lvl_o,
  output logic qual_o,
  output logic chg_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYC);
  localparam logic [CW-1:0] RUN_PRE = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lvl_o  <= 1'b0;
      run_q  <= '0;
      qual_o <= 1'b0;
      chg_o  <= 1'b0;
    end else if (bus_dom != lvl_o) begin
      lvl_o  <= bus_dom;
      run_q  <= CW'(1);
      qual_o <= (FILT_CYC == 1);
      chg_o  <= 1'b1;
    end else begin
      if (run_q != RUN_MAX) run_q <= run_q + CW'(1);
      qual_o <= (run_q == RUN_PRE);
      chg_o  <= 1'b0;
    end
  end

  p_run_capped_r2: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_MAX);
  p_qual_single_r1: assert property (@(posedge clk) disable iff (rst)
    qual_o |=> !qual_o);
endmodule

// File: rtl/wk_window_timer.sv
module wk_window_timer #(
  parameter int WIN_CYC = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic stop,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (start) begin
      run_q    <= 1'b1;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (stop || !run_q) begin
      run_q    <= 1'b0;
      expire_o <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      run_q    <= 1'b0;
      expire_o <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + CW'(1);
      expire_o <= 1'b0;
    end
  end

  p_window_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(WIN_CYC));
  p_expire_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> $past(run_q));
endmodule

// File: rtl/wk_seq.sv
module wk_seq
  import wk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pat_mode,
  input  logic lvl_i,
  input  logic qual_i,
  input  logic chg_i,
  input  logic expire_i,
  output logic win_start_o,
  output logic win_stop_o,
  output logic wake_o,
  output logic rxd_o
);
  wk_state_e st_q, st_d;
  logic      fire;

  always_comb begin
    st_d        = st_q;
    fire        = 1'b0;
    win_start_o = 1'b0;
    win_stop_o  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (qual_i && lvl_i) begin
          if (!pat_mode) begin
            fire = 1'b1;
            st_d = S_AWAKE;
          end else begin
            win_start_o = 1'b1;
            st_d        = S_DOM1;
          end
        end
      end
      S_DOM1:  if (chg_i) st_d = S_WREC;
      S_WREC: begin
        if (chg_i) begin
          win_stop_o = 1'b1;
          st_d       = S_IDLE;
        end else if (qual_i) begin
          st_d = S_REC;
        end
      end
      S_REC:   if (chg_i) st_d = S_WDOM2;
      S_WDOM2: begin
        if (chg_i) begin
          win_stop_o = 1'b1;
          st_d       = S_IDLE;
        end else if (qual_i) begin
          win_stop_o = 1'b1;
          fire       = 1'b1;
          st_d       = S_AWAKE;
        end
      end
      default: st_d = S_AWAKE;
    endcase
    if (expire_i && st_q != S_IDLE && st_q != S_AWAKE) begin
      fire = 1'b0;
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q   <= S_IDLE;
      wake_o <= 1'b0;
      rxd_o  <= 1'b1;
    end else begin
      st_q   <= st_d;
      wake_o <= fire;
      rxd_o  <= !((st_d == S_AWAKE) && lvl_i);
    end
  end

  p_pulse_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
  p_rxd_high_asleep_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_AWAKE) |-> rxd_o);
  p_silent_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wake_o);
  p_awake_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_AWAKE && en) |=> (st_q == S_AWAKE && !wake_o));
  p_wake_after_qual_r1: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(qual_i && lvl_i));
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect #(
  parameter int FILT_CYC = 450,
  parameter int WIN_CYC  = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_en,
  input  logic bus_dom,
  input  logic pattern_mode,
  output logic wake_pulse,
  output logic rxd_lp
);
  logic lvl, qual, chg, expire, win_start, win_stop;

  wk_phase_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .en(wake_en), .bus_dom(bus_dom),
    .lvl_o(lvl), .qual_o(qual), .chg_o(chg)
  );

  wk_window_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .clr(!wake_en), .start(win_start),
    .stop(win_stop), .expire_o(expire)
  );

  wk_seq u_seq (
    .clk(clk), .rst(rst), .en(wake_en), .pat_mode(pattern_mode),
    .lvl_i(lvl), .qual_i(qual), .chg_i(chg), .expire_i(expire),
    .win_start_o(win_start), .win_stop_o(win_stop),
    .wake_o(wake_pulse), .rxd_o(rxd_lp)
  );
endmodule

// File: tb/sim_can_wake_detect.sv
module sim_can_wake_detect;
  localparam int FILT = 8;
  localparam int WIN  = 60;
  localparam int NV   = 12;
  // {pattern_mode, first dominant, recessive, second dominant, expected pulses}
  localparam logic [25:0] VEC [0:NV-1] = '{
    {1'b0, 8'd9,  8'd0,  8'd0,  1'b1},  // R1 basic, just above filter
    {1'b0, 8'd7,  8'd0,  8'd0,  1'b0},  // R2 basic, just below filter
    {1'b0, 8'd7,  8'd3,  8'd7,  1'b0},  // R2 two short dominants
    {1'b0, 8'd9,  8'd9,  8'd9,  1'b1},  // R8 basic, only one pulse
    {1'b1, 8'd9,  8'd9,  8'd9,  1'b1},  // R3 pattern, all just above
    {1'b1, 8'd7,  8'd9,  8'd9,  1'b0},  // R4 first dominant short
    {1'b1, 8'd9,  8'd7,  8'd9,  1'b0},  // R4 recessive short
    {1'b1, 8'd9,  8'd9,  8'd7,  1'b0},  // R4 second dominant short
    {1'b1, 8'd9,  8'd70, 8'd9,  1'b0},  // R5 long recessive, window expires
    {1'b1, 8'd70, 8'd9,  8'd9,  1'b0},  // R5 long first dominant eats window
    {1'b1, 8'd20, 8'd20, 8'd10, 1'b1},  // R3 longer phases inside window
    {1'b1, 8'd9,  8'd5,  8'd9,  1'b0}   // R4 glitch then restart
  };

  logic clk = 1'b0;
  logic rst, wake_en, bus_dom, pattern_mode;
  logic wake_pulse, rxd_lp;
  int   checks = 0, fails = 0;
  int   pulses, early_low;
  bit   woke;

  always #4 clk = ~clk;

  can_wake_detect #(.FILT_CYC(FILT), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst(rst), .wake_en(wake_en), .bus_dom(bus_dom),
    .pattern_mode(pattern_mode), .wake_pulse(wake_pulse), .rxd_lp(rxd_lp)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wake_pulse) begin
        pulses = pulses + 1;
        woke   = 1'b1;
      end
      if (!woke && !rxd_lp) early_low = early_low + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic phase(input logic dom, input int n);
    for (int k = 0; k < n; k++) begin
      bus_dom = dom;
      @(negedge clk);
    end
  endtask

  task automatic arm(input logic mode);
    wake_en = 1'b0;
    bus_dom = 1'b0;
    pattern_mode = mode;
    phase(1'b0, 3);
    pulses = 0; early_low = 0; woke = 1'b0;
    wake_en = 1'b1;
    phase(1'b0, 4);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wake_en = 1'b0; bus_dom = 1'b0; pattern_mode = 1'b0;
    pulses = 0; early_low = 0; woke = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 wake_pulse after reset", wake_pulse, 0);
    check("R10 rxd_lp after reset", rxd_lp, 1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      arm(VEC[i][25]);
      phase(1'b1, int'(VEC[i][24:17]));
      phase(1'b0, int'(VEC[i][16:9]));
      phase(1'b1, int'(VEC[i][8:1]));
      phase(1'b0, 12);
      check($sformatf("R1/R2/R3/R4/R5 vector %0d pulse count", i), pulses, int'(VEC[i][0]));
      check($sformatf("R6 vector %0d rxd low before wake", i), early_low, 0);
    end

    // R7: receive data follows the bus after a wake-up
    arm(1'b0);
    phase(1'b1, 9);
    phase(1'b1, 4);
    check("R7 rxd low on dominant after wake", rxd_lp, 0);
    phase(1'b0, 4);
    check("R7 rxd high on recessive after wake", rxd_lp, 1);
    // R8: further activity ignored until re-armed
    phase(1'b1, 20);
    phase(1'b0, 5);
    check("R8 single pulse while awake", pulses, 1);
    arm(1'b0);
    phase(1'b1, 9);
    phase(1'b0, 6);
    check("R8 re-armed detector wakes again", pulses, 1);

    // R9: disabled detector never wakes and keeps rxd high
    wake_en = 1'b0;
    pulses = 0; early_low = 0; woke = 1'b0;
    phase(1'b1, 30);
    check("R9 no pulse while disabled", pulses, 0);
    check("R6 rxd high while disabled", rxd_lp, 1);
    phase(1'b0, 2);

    // R4: glitch in recessive, then a full pattern still wakes
    arm(1'b1);
    phase(1'b1, 9); phase(1'b0, 4); phase(1'b1, 9);
    phase(1'b0, 9); phase(1'b1, 9); phase(1'b0, 10);
    check("R4 restart then full pattern wakes", pulses, 1);

    finish_run();
  end
endmodule